// File: doc/BRIEF.md
# Diagnostic Address-Window Access Bridge

This block gives an external host access to any word of a 32-bit internal memory space through three byte-addressed window registers. The host side is a byte-wide register bus with address, write data, write strobe, read strobe and combinational read data. The internal side is a word-wide request/acknowledge port. Internal accesses are always full 32-bit words. The on-chip processor takes no part in these accesses.

Writes to the upper bytes of an address register only stage bits. Writing byte 0 of the read-address register starts an internal read. The fetched word lands in the data register, and the host then reads it out byte by byte. For a write, the host first fills the data register. Writing byte 0 of the write-address register then commits that word to the addressed location. Multi-word transfers repeat this with the address stepped by 4.

A trigger that arrives while an access is in flight is parked in a single pending slot and launched when the current access is acknowledged. A newer trigger overwrites an older one in the slot. Because of this, repeated byte-0 writes from a fixed-address host transfer start at most one extra, identical access.

Top module: `diag_window_bridge`

## Requirements
- R1: After reset, every window register reads 0x00 at each byte offset, `busy_o` is 0 and `mem_req_o` is 0.
- R2: The window is little-endian. The data register sits at host offsets 0x0-0x3, the read-address register at 0x4-0x7 and the write-address register at 0x8-0xB. Offset base+k holds bits 8k+7:8k. All three registers read back what was written. Offsets 0xC-0xF read 0x00, and writes to them are ignored.
- R3: A host write to byte 1, 2 or 3 of an address register, or to any byte of the data register, starts no internal access.
- R4: A host write of value V to offset 0x4 while idle raises `mem_req_o` with `mem_we_o`=0 on the next cycle. The address is {latched bytes 3..1, V}.
- R5: On the acknowledge of a read, the data register takes `mem_rdata_i`. Before that acknowledge, host reads of the data register return the previous contents.
- R6: A host write of value V to offset 0x8 while idle raises `mem_req_o` with `mem_we_o`=1. The address is {latched bytes 3..1, V}, and `mem_wdata_o` is the data register as it stood at the trigger.
- R7: `busy_o` follows `mem_req_o`. While the request waits for `mem_ack_i`, the address, direction and write data hold steady. Each acknowledge completes exactly one access.
- R8: A trigger that arrives while busy is launched immediately after the current acknowledge. It keeps the address and data it carried when written, and access order is preserved.
- R9: An ascending four-byte burst to an address register whose upper bytes already hold the written values starts exactly one access.
- R10: Four identical consecutive writes to byte 0 of the write-address register store the same word. They start no more than two accesses, both identical.
- R11: Words written at addresses stepped by 4 read back unchanged through the read window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hst_addr_i | input | HOST_AW | Host byte offset in the window |
| hst_wdata_i | input | 8 | Host write byte |
| hst_we_i | input | 1 | Host write strobe |
| hst_re_i | input | 1 | Host read strobe |
| hst_rdata_o | output | 8 | Host read byte (combinational, 0 when not reading) |
| mem_req_o | output | 1 | Internal access request |
| mem_we_o | output | 1 | Internal access is a write |
| mem_addr_o | output | 32 | Internal word address |
| mem_wdata_o | output | 32 | Internal write word |
| mem_ack_i | input | 1 | Internal access acknowledge |
| mem_rdata_i | input | 32 | Internal read word, valid with acknowledge |
| busy_o | output | 1 | Access in flight |

## Verification
Two kinds of state fault can show up at the ports. A corrupted staged address byte appears on the very next internal request as a wrong `mem_addr_o`. A lost or duplicated trigger appears as a missing or extra acknowledged access. The bench therefore compares every acknowledged access against an expected queue at the cycle it completes. A wrong data-register load becomes visible on the first host read after the acknowledge. Pending-slot faults show up at the end of the access in flight, as a reordered or missing second access.

// File: rtl/diag_win_pkg.sv
package diag_win_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned WORD_BYTES = WORD_W / 8;
  localparam int unsigned BSEL_W     = $clog2(WORD_BYTES);
  localparam int unsigned N_REGS     = 3;
  // register order on the host bus (byte offset = index * WORD_BYTES)
  localparam int unsigned IDX_DATA   = 0;
  localparam int unsigned IDX_RADDR  = 1;
  localparam int unsigned IDX_WADDR  = 2;

  typedef struct packed {
    logic              we;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] wdata;
  } win_cmd_t;
endpackage

// File: rtl/diag_win_reg.sv
module diag_win_reg #(
  parameter int unsigned W  = 32,
  localparam int unsigned NB = W / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] bwe_i,
  input  logic [7:0]    bdata_i,
  input  logic          ld_i,
  input  logic [W-1:0]  ld_data_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (ld_i) begin
      q <= ld_data_i; // internal load wins over a same-cycle host byte write
    end else begin
      for (int b = 0; b < int'(NB); b++) begin
        if (bwe_i[b]) q[8*b +: 8] <= bdata_i;
      end
    end
  end

  assign q_o = q;
endmodule

// File: rtl/diag_win_seq.sv
module diag_win_seq
  import diag_win_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     trig_v_i,
  input  win_cmd_t trig_cmd_i,
  input  logic     ack_i,
  output logic     busy_o,
  output win_cmd_t cmd_o,
  output logic     rd_done_o
);
  logic     busy_q, pend_q;
  win_cmd_t cur_q, pend_cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      pend_q     <= 1'b0;
      cur_q      <= '0;
      pend_cmd_q <= '0;
    end else if (!busy_q) begin
      if (trig_v_i) begin
        busy_q <= 1'b1;
        cur_q  <= trig_cmd_i;
      end
    end else if (ack_i) begin
      if (pend_q) begin
        // chain the parked trigger; a same-cycle trigger refills the slot
        cur_q  <= pend_cmd_q;
        pend_q <= trig_v_i;
        if (trig_v_i) pend_cmd_q <= trig_cmd_i;
      end else if (trig_v_i) begin
        cur_q <= trig_cmd_i;
      end else begin
        busy_q <= 1'b0;
      end
    end else if (trig_v_i) begin
      // single slot: newest trigger wins
      pend_q     <= 1'b1;
      pend_cmd_q <= trig_cmd_i;
    end
  end

  assign busy_o    = busy_q;
  assign cmd_o     = cur_q;
  assign rd_done_o = busy_q && ack_i && !cur_q.we;
endmodule

// File: rtl/diag_window_bridge.sv
module diag_window_bridge
  import diag_win_pkg::*;
#(
  parameter int unsigned HOST_AW = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HOST_AW-1:0] hst_addr_i,
  input  logic [7:0]         hst_wdata_i,
  input  logic               hst_we_i,
  input  logic               hst_re_i,
  output logic [7:0]         hst_rdata_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [WORD_W-1:0]  mem_addr_o,
  output logic [WORD_W-1:0]  mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               busy_o
);
  localparam int unsigned SEL_W = HOST_AW - BSEL_W;

  logic [SEL_W-1:0]  reg_sel;
  logic [BSEL_W-1:0] byte_sel;
  logic [WORD_W-1:0] reg_q [N_REGS];
  logic              rd_done;
  logic              trig_v;
  win_cmd_t          trig_cmd, cur_cmd;
  logic [WORD_W-9:0] src_hi;
  logic [WORD_W-1:0] rd_word;

  assign reg_sel  = hst_addr_i[HOST_AW-1:BSEL_W];
  assign byte_sel = hst_addr_i[BSEL_W-1:0];

  for (genvar r = 0; r < int'(N_REGS); r++) begin : g_reg
    logic                  hit;
    logic [WORD_BYTES-1:0] bwe;
    assign hit = hst_we_i && (reg_sel == SEL_W'(r));
    always_comb begin
      bwe = '0;
      if (hit) bwe[byte_sel] = 1'b1;
    end
    if (r == int'(IDX_DATA)) begin : g_data
      diag_win_reg #(.W(WORD_W)) i_reg (
        .clk_i(clk_i), .rst_ni(rst_ni), .bwe_i(bwe), .bdata_i(hst_wdata_i),
        .ld_i(rd_done), .ld_data_i(mem_rdata_i), .q_o(reg_q[r])
      );
    end else begin : g_addr
      diag_win_reg #(.W(WORD_W)) i_reg (
        .clk_i(clk_i), .rst_ni(rst_ni), .bwe_i(bwe), .bdata_i(hst_wdata_i),
        .ld_i(1'b0), .ld_data_i('0), .q_o(reg_q[r])
      );
    end
  end

  // byte-0 write of an address register launches the access
  assign trig_v = hst_we_i && (byte_sel == '0) &&
                  ((reg_sel == SEL_W'(IDX_RADDR)) || (reg_sel == SEL_W'(IDX_WADDR)));
  assign src_hi = (reg_sel == SEL_W'(IDX_WADDR)) ? reg_q[IDX_WADDR][WORD_W-1:8]
                                                 : reg_q[IDX_RADDR][WORD_W-1:8];
  always_comb begin
    trig_cmd.we    = (reg_sel == SEL_W'(IDX_WADDR));
    trig_cmd.addr  = {src_hi, hst_wdata_i};
    trig_cmd.wdata = reg_q[IDX_DATA];
  end

  diag_win_seq i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_v_i(trig_v), .trig_cmd_i(trig_cmd),
    .ack_i(mem_ack_i), .busy_o(busy_o), .cmd_o(cur_cmd), .rd_done_o(rd_done)
  );

  assign mem_req_o   = busy_o;
  assign mem_we_o    = cur_cmd.we;
  assign mem_addr_o  = cur_cmd.addr;
  assign mem_wdata_o = cur_cmd.wdata;

  always_comb begin
    rd_word = '0;
    for (int r = 0; r < int'(N_REGS); r++) begin
      if (reg_sel == SEL_W'(r)) rd_word = reg_q[r];
    end
    hst_rdata_o = hst_re_i ? rd_word[{byte_sel, 3'b000} +: 8] : 8'h00;
  end
endmodule

// File: rtl/diag_win_chk.sv
module diag_win_chk
  import diag_win_pkg::*;
#(
  parameter int unsigned HOST_AW = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [HOST_AW-1:0] hst_addr_i,
  input logic [7:0]         hst_wdata_i,
  input logic               hst_we_i,
  input logic               hst_re_i,
  input logic [7:0]         hst_rdata_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [WORD_W-1:0]  mem_addr_o,
  input logic [WORD_W-1:0]  mem_wdata_o,
  input logic               mem_ack_i,
  input logic [WORD_W-1:0]  mem_rdata_i
);
  localparam int unsigned SEL_W = HOST_AW - BSEL_W;
  logic [SEL_W-1:0] sel;
  logic             b0;
  assign sel = hst_addr_i[HOST_AW-1:BSEL_W];
  assign b0  = (hst_addr_i[BSEL_W-1:0] == '0);

  assert_no_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_we_i && !b0 && !mem_req_o) |=> !mem_req_o);

  assert_start_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(hst_we_i && b0 &&
      (sel == SEL_W'(IDX_RADDR) || sel == SEL_W'(IDX_WADDR))));

  assert_start_lsb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> (mem_addr_o[7:0] == $past(hst_wdata_i)));

  assert_write_dir_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_req_o) && mem_we_o) |-> ($past(sel) == SEL_W'(IDX_WADDR)));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_rd_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_re_i && sel == SEL_W'(IDX_DATA) && b0 &&
     $past(mem_ack_i && mem_req_o && !mem_we_o)) |-> (hst_rdata_o == $past(mem_rdata_i[7:0])));
endmodule

bind diag_window_bridge diag_win_chk #(.HOST_AW(HOST_AW)) i_chk (.*);

// File: tb/test_diag_window_bridge.sv
module test_diag_window_bridge;
  import diag_win_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int HOST_AW    = 4;
  localparam int ACK_LAT    = 3;
  localparam int WDOG_CYC   = 20000;

  logic               clk, rst_n;
  logic [HOST_AW-1:0] h_addr;
  logic [7:0]         h_wdata, h_rdata;
  logic               h_we, h_re;
  logic               m_req, m_we, m_ack, busy;
  logic [31:0]        m_addr, m_wdata, m_rdata;

  diag_window_bridge #(.HOST_AW(HOST_AW)) i_diag_window_bridge (
    .clk_i(clk), .rst_ni(rst_n), .hst_addr_i(h_addr), .hst_wdata_i(h_wdata),
    .hst_we_i(h_we), .hst_re_i(h_re), .hst_rdata_o(h_rdata),
    .mem_req_o(m_req), .mem_we_o(m_we), .mem_addr_o(m_addr), .mem_wdata_o(m_wdata),
    .mem_ack_i(m_ack), .mem_rdata_i(m_rdata), .busy_o(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, n_acc = 0;
  win_cmd_t exp_q[$];
  logic [31:0] mem [logic [31:0]];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model and scoreboard monitor: acks after ACK_LAT waiting cycles
  initial begin
    int wait_cnt;
    win_cmd_t e;
    wait_cnt = 0; m_ack = 1'b0; m_rdata = '0;
    forever begin
      @(negedge clk);
      if (m_ack) begin
        m_ack = 1'b0;
        wait_cnt = 0;
      end else if (rst_n && m_req) begin
        if (wait_cnt == ACK_LAT) begin
          wait_cnt = 0;
          m_ack = 1'b1;
          n_acc++;
          m_rdata = mem.exists(m_addr) ? mem[m_addr] : ~m_addr;
          if (m_we) mem[m_addr] = m_wdata;
          n_chk++;
          if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R7 unexpected access: actual we=%0b addr=%h data=%h expected none",
                     m_we, m_addr, m_wdata);
          end else begin
            e = exp_q.pop_front();
            if (e.we !== m_we || e.addr !== m_addr || (e.we && e.wdata !== m_wdata)) begin
              n_fail++;
              $display("FAIL R4 R6 R8 access: actual we=%0b addr=%h data=%h expected we=%0b addr=%h data=%h",
                       m_we, m_addr, m_wdata, e.we, e.addr, e.wdata);
            end
          end
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d);
    win_cmd_t c;
    c.we = we; c.addr = a; c.wdata = d;
    exp_q.push_back(c);
  endtask

  // all host tasks start and end at a falling edge
  task automatic hwr(input logic [HOST_AW-1:0] a, input logic [7:0] d);
    h_addr = a; h_wdata = d; h_we = 1'b1;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic hrd(input logic [HOST_AW-1:0] a, output logic [7:0] d);
    h_addr = a; h_re = 1'b1;
    #1 d = h_rdata;
    @(negedge clk);
    h_re = 1'b0;
  endtask

  task automatic rd_word(input logic [HOST_AW-1:0] base, output logic [31:0] w);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      hrd(base + HOST_AW'(k), b);
      w[8*k +: 8] = b;
    end
  endtask

  task automatic wr_data(input logic [31:0] w);
    for (int k = 0; k < 4; k++) hwr(HOST_AW'(k), w[8*k +: 8]);
  endtask

  task automatic wr_addr(input logic [HOST_AW-1:0] base, input logic [31:0] a);
    for (int k = 1; k < 4; k++) hwr(base + HOST_AW'(k), a[8*k +: 8]);
    hwr(base, a[7:0]);
  endtask

  task automatic wait_idle();
    int g;
    g = 0;
    while (busy && g < 1000) begin
      @(negedge clk);
      g++;
    end
  endtask

  initial begin
    #(WDOG_CYC * CLK_PERIOD);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w, a0;
    logic [7:0]  b;
    int          acc0;
    rst_n = 1'b0; h_addr = '0; h_wdata = '0; h_we = 1'b0; h_re = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", 32'(busy), 0);
    check("R1 req", 32'(m_req), 0);
    for (int k = 0; k < 12; k++) begin
      hrd(HOST_AW'(k), b);
      check("R1 reg byte", 32'(b), 0);
    end

    // R2 unmapped offset ignored, R3 upper bytes stage only
    hwr(4'hC, 8'h5A);
    hrd(4'hC, b);
    check("R2 unmapped", 32'(b), 0);
    hwr(4'h5, 8'h12); check("R3 no start b1", 32'(m_req), 0);
    hwr(4'h6, 8'h34); check("R3 no start b2", 32'(m_req), 0);
    hwr(4'h7, 8'h56); check("R3 no start b3", 32'(m_req), 0);
    rd_word(4'h4, w);
    check("R2 readback little-endian", w, 32'h5634_1200);

    // R4 read launch, R5 old data while busy, R7 hold
    a0 = 32'h5634_12A0;
    mem[a0] = 32'hCAFE_F00D;
    push(1'b0, a0, '0);
    hwr(4'h4, 8'hA0);
    check("R4 req", 32'(m_req), 1);
    check("R4 dir", 32'(m_we), 0);
    check("R4 addr", m_addr, a0);
    check("R7 busy", 32'(busy), 1);
    hrd(4'h0, b);
    check("R5 old data while busy", 32'(b), 0);
    check("R7 addr hold", m_addr, a0);
    wait_idle();
    rd_word(4'h0, w);
    check("R5 loaded data", w, 32'hCAFE_F00D);

    // R6 write commit
    wr_data(32'h1122_3344);
    push(1'b1, 32'h1000_0040, 32'h1122_3344);
    wr_addr(4'h8, 32'h1000_0040);
    check("R6 dir", 32'(m_we), 1);
    check("R6 wdata", m_wdata, 32'h1122_3344);
    wait_idle();
    check("R6 stored", mem[32'h1000_0040], 32'h1122_3344);

    // R9 ascending burst after staging
    mem[32'h0000_2000] = 32'h0BAD_BEEF;
    hwr(4'h5, 8'h20); hwr(4'h6, 8'h00); hwr(4'h7, 8'h00);
    acc0 = n_acc;
    push(1'b0, 32'h0000_2000, '0);
    hwr(4'h4, 8'h00); hwr(4'h5, 8'h20); hwr(4'h6, 8'h00); hwr(4'h7, 8'h00);
    wait_idle();
    check("R9 single access", 32'(n_acc - acc0), 1);
    rd_word(4'h0, w);
    check("R9 data", w, 32'h0BAD_BEEF);

    // R10 fixed-address mode: each byte written four times
    wr_data(32'h7788_99AA);
    for (int k = 1; k < 4; k++)
      for (int r = 0; r < 4; r++) hwr(4'h8 + HOST_AW'(k), (k == 1) ? 8'h30 : 8'h00);
    acc0 = n_acc;
    push(1'b1, 32'h0000_3000, 32'h7788_99AA);
    push(1'b1, 32'h0000_3000, 32'h7788_99AA);
    for (int r = 0; r < 4; r++) hwr(4'h8, 8'h00);
    wait_idle();
    check("R10 at most two accesses", 32'(n_acc - acc0), 2);
    check("R10 stored", mem[32'h0000_3000], 32'h7788_99AA);

    // R8 trigger while busy is deferred, order kept
    mem[32'h0000_4000] = 32'h1357_9BDF;
    hwr(4'h5, 8'h40);
    hwr(4'h9, 8'h50);
    wr_data(32'hFEDC_BA98);
    acc0 = n_acc;
    push(1'b0, 32'h0000_4000, '0);
    push(1'b1, 32'h0000_5004, 32'hFEDC_BA98);
    hwr(4'h4, 8'h00);
    hwr(4'h8, 8'h04);
    check("R8 still on first", m_addr, 32'h0000_4000);
    wait_idle();
    check("R8 two accesses", 32'(n_acc - acc0), 2);
    check("R8 deferred write", mem[32'h0000_5004], 32'hFEDC_BA98);
    check("R8 queue drained", 32'(exp_q.size()), 0);

    // R11 multi-word stepping by 4
    for (int k = 0; k < 4; k++) begin
      w = 32'hA500_0000 + 32'(k) * 32'h0101_0101;
      wr_data(w);
      push(1'b1, 32'h100 + 32'(4*k), w);
      wr_addr(4'h8, 32'h100 + 32'(4*k));
      wait_idle();
    end
    for (int k = 0; k < 4; k++) begin
      push(1'b0, 32'h100 + 32'(4*k), '0);
      wr_addr(4'h4, 32'h100 + 32'(4*k));
      wait_idle();
      rd_word(4'h0, w);
      check("R11 word readback", w, 32'hA500_0000 + 32'(k) * 32'h0101_0101);
    end
    check("R11 queue drained", 32'(exp_q.size()), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule